// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode sequencer beside a single-wire LIN bus driver. It keeps the transceiver in one of four operating modes: normal slope, low slope, standby and sleep. From that mode it drives the regulator enable, the transmitter enable, the slope select, the termination select, the inhibit output and the receive-data pin. A host microcontroller selects the mode through three asynchronous pins: enable, standby and transmit data. The wake detectors of the analog front end and the thermal monitor feed the block with synchronous event and flag inputs.

The enable pin acts on its edges. When enable rises, the level of transmit data picks the slope, and the level of the standby pin fixes the inhibit output for the whole stay in the normal mode. When enable falls, the standby pin chooses between standby and sleep. In standby the receive-data pin shows which wake source brought the block there: low for a bus wake, high for a local wake or a fresh power-up.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After power-on reset the block is in standby: reg_en=1, tx_en=0, slope_low=0, term_res=0, inh_drive=0, rxd=1.
- R2: A rising enable edge in standby with transmit data high enters normal slope mode: reg_en=1, tx_en=1, slope_low=0, term_res=1.
- R3: A rising enable edge in standby with transmit data low enters low slope mode (slope_low=1, term_res=1). tx_en stays 0 until transmit data is seen high. After that it stays 1 even if transmit data goes low again.
- R4: In either normal mode inh_drive is 1 if the standby pin was high in the cycle of the enable edge, and 0 otherwise. Later changes of the standby pin do not change inh_drive.
- R5: A falling enable edge in a normal mode with the standby pin high enters standby: reg_en=1, tx_en=0, term_res=0, inh_drive=0.
- R6: A falling enable edge in a normal mode with the standby pin low enters sleep: reg_en=0, tx_en=0, term_res=0, inh_drive=0, rxd=1.
- R7: A wake_local pulse in sleep enters standby with rxd=1.
- R8: A wake_bus pulse in sleep enters standby with rxd=0. rxd stays 0 until a normal mode is entered.
- R9: A wake_bus pulse in standby drives rxd to 0, and the block stays in standby.
- R10: In either normal mode rxd equals bus_rx (0 = dominant, 1 = recessive).
- R11: While tsd_flag is 1, reg_en and tx_en are 0. The mode is kept, and both return when the flag clears.
- R12: In sleep a rising enable edge has no effect. The block stays in sleep until a wake event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| en_pin | input | 1 | Mode enable pin, asynchronous |
| stb_pin | input | 1 | Standby select pin, asynchronous |
| txd_pin | input | 1 | Transmit data pin, asynchronous, low = dominant |
| wake_local | input | 1 | One-cycle local wake event |
| wake_bus | input | 1 | One-cycle remote bus wake event |
| tsd_flag | input | 1 | Thermal shutdown active |
| bus_rx | input | 1 | Filtered bus level, 0 = dominant |
| reg_en | output | 1 | Voltage regulator enable |
| tx_en | output | 1 | Bus transmitter enable |
| slope_low | output | 1 | 1 selects the reduced slew rate |
| term_res | output | 1 | 1 = resistive termination, 0 = pull-up current source |
| inh_drive | output | 1 | 1 drives the inhibit pin high, 0 leaves it floating |
| rxd | output | 1 | Receive-data pin value |

## Verification
Every entry into a normal mode is tried with both transmit data levels, so that slope selection and transmitter arming are told apart. Both standby pin levels are also used at entry and at exit, which separates the latched inhibit value from the standby-or-sleep choice on the way out. Bus wakes and local wakes are applied in sleep and in standby, and the resulting receive-data level shows whether the wake source was recorded and later cleared by normal entry. A thermal pulse during normal mode, and an enable edge during sleep, show that the gating and the ignored inputs leave the stored mode untouched.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

   typedef enum logic [1:0] {
      MD_STANDBY  = 2'd0,
      MD_SLEEP    = 2'd1,
      MD_NORMAL   = 2'd2,
      MD_LOWSLOPE = 2'd3
   } lin_mode_e;

   typedef struct packed {
      logic en;
      logic stb;
      logic txd;
   } pin_set_t;

   localparam int PIN_COUNT = $bits(pin_set_t);

   typedef struct packed {
      logic reg_en;
      logic tx_en;
      logic slope_low;
      logic term_res;
      logic inh_drive;
      logic rxd;
   } drive_t;

endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lin_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lin_pin_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
   import lin_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pin_set_t  pins,
   input  logic      wake_local,
   input  logic      wake_bus,
   output lin_mode_e mode,
   output logic      inh_hold,
   output logic      tx_armed,
   output logic      remote_wake
);

   logic      en_d;
   logic      en_rise;
   logic      en_fall;
   lin_mode_e mode_n;
   logic      inh_n;
   logic      arm_n;
   logic      rem_n;

   assign en_rise = pins.en & ~en_d;
   assign en_fall = ~pins.en & en_d;

   always_comb begin
      mode_n = mode;
      inh_n  = inh_hold;
      arm_n  = tx_armed;
      rem_n  = remote_wake;
      case (mode)
         MD_STANDBY: begin
            if (en_rise) begin
               mode_n = pins.txd ? MD_NORMAL : MD_LOWSLOPE;
               inh_n  = pins.stb;
               arm_n  = pins.txd;
               rem_n  = 1'b0;
            end else if (wake_bus) begin
               rem_n = 1'b1;
            end
         end
         MD_SLEEP: begin
            if (wake_bus) begin
               mode_n = MD_STANDBY;
               rem_n  = 1'b1;
            end else if (wake_local) begin
               mode_n = MD_STANDBY;
               rem_n  = 1'b0;
            end
         end
         MD_NORMAL, MD_LOWSLOPE: begin
            if (en_fall) begin
               mode_n = pins.stb ? MD_STANDBY : MD_SLEEP;
               inh_n  = 1'b0;
               arm_n  = 1'b0;
            end else if (pins.txd) begin
               arm_n = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d        <= 1'b0;
         mode        <= MD_STANDBY;
         inh_hold    <= 1'b0;
         tx_armed    <= 1'b0;
         remote_wake <= 1'b0;
      end else begin
         en_d        <= pins.en;
         mode        <= mode_n;
         inh_hold    <= inh_n;
         tx_armed    <= arm_n;
         remote_wake <= rem_n;
      end
   end

endmodule

// File: rtl/lin_out_decode.sv
module lin_out_decode
   import lin_mode_pkg::*;
(
   input  lin_mode_e mode,
   input  logic      inh_hold,
   input  logic      tx_armed,
   input  logic      remote_wake,
   input  logic      tsd,
   input  logic      bus_rx,
   output drive_t    drv
);

   always_comb begin
      drv = '0;
      case (mode)
         MD_STANDBY: begin
            drv.reg_en = ~tsd;
            drv.rxd    = ~remote_wake;
         end
         MD_SLEEP: begin
            drv.rxd = 1'b1;
         end
         MD_NORMAL, MD_LOWSLOPE: begin
            drv.reg_en    = ~tsd;
            drv.tx_en     = tx_armed & ~tsd;
            drv.slope_low = (mode == MD_LOWSLOPE);
            drv.term_res  = 1'b1;
            drv.inh_drive = inh_hold;
            drv.rxd       = bus_rx;
         end
      endcase
   end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic en_pin,
   input  logic stb_pin,
   input  logic txd_pin,
   input  logic wake_local,
   input  logic wake_bus,
   input  logic tsd_flag,
   input  logic bus_rx,
   output logic reg_en,
   output logic tx_en,
   output logic slope_low,
   output logic term_res,
   output logic inh_drive,
   output logic rxd
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lin_mode_ctrl: SYNC_STAGES must be at least 2");
   end

   pin_set_t  raw_pins;
   pin_set_t  sync_pins;
   lin_mode_e mode;
   logic      inh_hold;
   logic      tx_armed;
   logic      remote_wake;
   drive_t    drv;

   assign raw_pins = '{en: en_pin, stb: stb_pin, txd: txd_pin};

   lin_pin_sync #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (raw_pins),
      .q     (sync_pins)
   );

   lin_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (por_n),
      .pins        (sync_pins),
      .wake_local  (wake_local),
      .wake_bus    (wake_bus),
      .mode        (mode),
      .inh_hold    (inh_hold),
      .tx_armed    (tx_armed),
      .remote_wake (remote_wake)
   );

   lin_out_decode u_dec (
      .mode        (mode),
      .inh_hold    (inh_hold),
      .tx_armed    (tx_armed),
      .remote_wake (remote_wake),
      .tsd         (tsd_flag),
      .bus_rx      (bus_rx),
      .drv         (drv)
   );

   assign reg_en    = drv.reg_en;
   assign tx_en     = drv.tx_en;
   assign slope_low = drv.slope_low;
   assign term_res  = drv.term_res;
   assign inh_drive = drv.inh_drive;
   assign rxd       = drv.rxd;

endmodule

module lin_mode_ctrl_chk (
   input logic clk,
   input logic por_n,
   input logic wake_local,
   input logic wake_bus,
   input logic tsd_flag,
   input logic bus_rx,
   input logic reg_en,
   input logic tx_en,
   input logic slope_low,
   input logic term_res,
   input logic inh_drive,
   input logic rxd
);

   // R11
   thermal_cut_chk: assert property (@(posedge clk) disable iff (!por_n)
      tsd_flag |-> (!reg_en && !tx_en));

   // R6
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!reg_en && !tsd_flag) |-> (!tx_en && !term_res && !inh_drive && rxd));

   // R5
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      !term_res |-> (!tx_en && !inh_drive && !slope_low));

   // R10
   normal_rx_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
      term_res |-> (rxd == bus_rx));

   // R7
   local_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!reg_en && !tsd_flag && wake_local && !wake_bus) |=> (tsd_flag || (reg_en && rxd)));

   // R8
   bus_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!reg_en && !tsd_flag && wake_bus) |=> (tsd_flag || (reg_en && !rxd)));

   // R9
   standby_bus_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
      (reg_en && !term_res && wake_bus) |=> (tsd_flag || !rxd));

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .wake_local (wake_local),
   .wake_bus   (wake_bus),
   .tsd_flag   (tsd_flag),
   .bus_rx     (bus_rx),
   .reg_en     (reg_en),
   .tx_en      (tx_en),
   .slope_low  (slope_low),
   .term_res   (term_res),
   .inh_drive  (inh_drive),
   .rxd        (rxd)
);

// File: tb/lin_mode_ctrl_test.sv
`timescale 1ns/1ps
module lin_mode_ctrl_test;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic en_pin = 1'b0, stb_pin = 1'b0, txd_pin = 1'b1;
   logic wake_local = 1'b0, wake_bus = 1'b0, tsd_flag = 1'b0, bus_rx = 1'b1;
   logic reg_en, tx_en, slope_low, term_res, inh_drive, rxd;
   int   n_chk = 0;
   int   n_fail = 0;

   // output vector order: {reg_en, tx_en, slope_low, term_res, inh_drive, rxd}
   localparam logic [5:0] STBY      = 6'b100001;
   localparam logic [5:0] STBY_BUS  = 6'b100000;
   localparam logic [5:0] SLEEP     = 6'b000001;
   localparam logic [5:0] NORM      = 6'b110101;
   localparam logic [5:0] NORM_INH  = 6'b110111;
   localparam logic [5:0] LOW_WAIT  = 6'b101101;
   localparam logic [5:0] LOW_ARMED = 6'b111101;

   always #4 clk = ~clk;

   lin_mode_ctrl uut (
      .clk(clk), .por_n(por_n), .en_pin(en_pin), .stb_pin(stb_pin), .txd_pin(txd_pin),
      .wake_local(wake_local), .wake_bus(wake_bus), .tsd_flag(tsd_flag), .bus_rx(bus_rx),
      .reg_en(reg_en), .tx_en(tx_en), .slope_low(slope_low), .term_res(term_res),
      .inh_drive(inh_drive), .rxd(rxd)
   );

   task automatic chk(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {reg_en, tx_en, slope_low, term_res, inh_drive, rxd};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs got %b expected %b", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      settle();
      chk("R1 reset state", STBY);
   endtask

   task automatic t_enter_normal(input logic stb, input logic [5:0] exp);
      @(negedge clk);
      stb_pin = stb; txd_pin = 1'b1; en_pin = 1'b1;
      settle();
      chk(stb ? "R2 R4 normal with inh" : "R2 R4 normal no inh", exp);
      stb_pin = ~stb;
      settle();
      chk("R4 inh ignores later stb", exp);
      bus_rx = 1'b0;
      settle();
      chk("R10 rxd dominant", exp & 6'b111110);
      bus_rx = 1'b1;
      settle();
   endtask

   task automatic t_leave(input logic stb);
      @(negedge clk);
      stb_pin = stb; en_pin = 1'b0;
      settle();
      if (stb) chk("R5 exit to standby", STBY);
      else     chk("R6 exit to sleep", SLEEP);
   endtask

   task automatic t_low_slope();
      @(negedge clk);
      stb_pin = 1'b0; txd_pin = 1'b0; en_pin = 1'b1;
      settle();
      chk("R3 low slope tx held off", LOW_WAIT);
      txd_pin = 1'b1;
      settle();
      chk("R3 low slope armed", LOW_ARMED);
      txd_pin = 1'b0;
      settle();
      chk("R3 stays armed", LOW_ARMED);
      txd_pin = 1'b1;
   endtask

   task automatic t_sleep_en();
      @(negedge clk);
      en_pin = 1'b1; txd_pin = 1'b1;
      settle();
      chk("R12 en ignored in sleep", SLEEP);
      en_pin = 1'b0;
      settle();
      chk("R12 still sleep", SLEEP);
   endtask

   task automatic pulse(input logic bus);
      @(negedge clk);
      if (bus) wake_bus = 1'b1; else wake_local = 1'b1;
      @(negedge clk);
      wake_bus = 1'b0; wake_local = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_thermal();
      @(negedge clk);
      tsd_flag = 1'b1;
      @(negedge clk);
      chk("R11 thermal cut", 6'b000101);
      tsd_flag = 1'b0;
      @(negedge clk);
      chk("R11 thermal release", NORM);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      report();
   end

   initial begin
      t_reset();
      t_enter_normal(1'b1, NORM_INH);
      t_leave(1'b1);
      t_enter_normal(1'b0, NORM);
      t_leave(1'b0);
      t_sleep_en();
      pulse(1'b0);
      chk("R7 local wake to standby", STBY);
      pulse(1'b1);
      chk("R9 bus wake in standby", STBY_BUS);
      t_enter_normal(1'b0, NORM);
      t_leave(1'b0);
      pulse(1'b1);
      chk("R8 bus wake from sleep", STBY_BUS);
      settle();
      chk("R8 rxd held low", STBY_BUS);
      t_enter_normal(1'b0, NORM);
      t_thermal();
      t_leave(1'b1);
      t_low_slope();
      t_leave(1'b0);
      report();
   end

endmodule